// File: doc/BRIEF.md
# Reset Release Sequencer

This block keeps a processor core in reset after a power-on pulse, a filtered brown-out or a wake from sleep. It releases the core only after the required delays have run. Two delays are counted. The power-up timer counts ticks of a slow internal timing clock. The start-up counter counts oscillator-clock cycles and gives a crystal or resonator time to settle. The analog supply comparators and the oscillators are outside the block. Each comparator shows up as one digital flag that reads 1 while the supply is below its trip level.

Four comparator flags come in, and a 2-bit select picks the one that counts. The slow clock is a one-cycle enable, `slow_tick_i`, that is already synchronous to `clk`. The power-on pulse `por_i` resets the block asynchronously. No data moves through the block, so every pin is a plain control or status line and there is no valid/ready handshake. A status field reports whether the last reset came from power-on, brown-out or wake. A new power-on pulse clears it back to power-on.

Top module: `reset_release_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1, `cause_por_o` is 1, and `cause_bor_o` and `cause_wake_o` are 0.
- R2: `core_rst_o` stays high from any reset event until every delay that event needs has completed. It is low only in the running phase.
- R3: The power-up timer counts PWRT_TICKS pulses of `slow_tick_i`. It ignores `clk` cycles that carry no tick, and it holds the core in reset for the whole count.
- R4: After a power-on pulse with `pwrt_en_i` low, the power-up timer is skipped.
- R5: If `osc_mode_i` is 0, 1 or 2 (the crystal/resonator codes), a start-up count of OST_CYCLES `clk` cycles (1024 by default) runs after the timer stage and before release. Codes 3 to 7 skip this count.
- R6: The selected flag must stay at 1 across FILTER_TICKS slow ticks before it counts as a brown-out. A shorter low-supply pulse leaves the core running and the cause unchanged.
- R7: `bor_sel_i` gives the index of the flag in `bor_flag_i` that is used. The other flags have no effect.
- R8: When `bor_en_i` is 0, no flag can cause a brown-out.
- R9: A qualified brown-out asserts `core_rst_o` and sets `cause_bor_o`. Reset is held for as long as the selected flag stays at 1.
- R10: When the selected flag returns to 0 after a brown-out, the power-up timer runs whatever the value of `pwrt_en_i`.
- R11: If the selected flag goes to 1 while the power-up timer runs, the sequencer returns to brown-out at once. When the flag clears, the timer starts again from zero.
- R12: A `wake_i` pulse while running sets `cause_wake_o`. With a crystal code it holds the core in reset for the start-up count. With any other code the core keeps running.
- R13: Exactly one cause flag is set at any time, and it names the most recent reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bor_flag_i | input | 4 | Brown-out comparator flags, 1 = supply below that trip level |
| bor_sel_i | input | 2 | Index of the flag in use |
| bor_en_i | input | 1 | Brown-out detection enable |
| pwrt_en_i | input | 1 | Power-up timer enable for the power-on path |
| osc_mode_i | input | 3 | Oscillator mode code; 0 to 2 are crystal/resonator modes |
| wake_i | input | 1 | Wake-from-sleep request, one cycle |
| slow_tick_i | input | 1 | Slow-clock tick enable, synchronous to clk |
| core_rst_o | output | 1 | Reset to the core, active high |
| cause_por_o | output | 1 | Last reset came from power-on |
| cause_bor_o | output | 1 | Last reset came from brown-out |
| cause_wake_o | output | 1 | Last reset came from wake |

## Verification
Every output comes from a register. A change of phase or of cause therefore shows up one `clk` edge after the input or counter condition that causes it. The one exception is `por_i`, which takes effect as soon as it rises. The bench changes inputs just after a falling edge. A behavioural model steps on each rising edge, and the outputs are compared with it at each falling edge. The directed timing checks give windows in whole cycles. The timer stage lasts PWRT_TICKS ticks of period four, so release comes between 29 and 33 cycles after its trigger. The start-up stage adds exactly OST_CYCLES cycles. Each check samples well inside a window that the requirements fix.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic [2:0] {
    PH_POR      = 3'd0,
    PH_BROWNOUT = 3'd1,
    PH_PWRT     = 3'd2,
    PH_OST      = 3'd3,
    PH_RUN      = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    CAUSE_POR  = 2'd0,
    CAUSE_BOR  = 2'd1,
    CAUSE_WAKE = 2'd2
  } cause_e;

  localparam int CRYSTAL_MAX_CODE = 2;

  function automatic logic is_crystal(input logic [2:0] mode);
    return (mode <= 3'(CRYSTAL_MAX_CODE));
  endfunction

endpackage

// File: rtl/rrs_bor_filter.sv
module rrs_bor_filter #(
  parameter int LEVELS       = 4,
  parameter int FILTER_TICKS = 3,
  localparam int SEL_W       = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic [LEVELS-1:0] flags_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              en_i,
  input  logic              tick_i,
  output logic              low_o,
  output logic              trip_o
);

  localparam int CW = $clog2(FILTER_TICKS + 1);
  localparam logic [CW-1:0] CMAX = CW'(FILTER_TICKS);

  logic          sel_flag;
  logic [CW-1:0] cnt;

  assign sel_flag = flags_i[sel_i];
  assign low_o    = en_i & sel_flag;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      cnt <= '0;
    end else if (!low_o) begin
      cnt <= '0;
    end else if (tick_i && (cnt != CMAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign trip_o = low_o && (cnt == CMAX);

  // R6
  filter_needs_history_chk: assert property (@(posedge clk) disable iff (por_i)
    trip_o |-> $past(low_o));

  // R8
  filter_disabled_chk: assert property (@(posedge clk) disable iff (por_i)
    !en_i |-> !trip_o);

endmodule

// File: rtl/rrs_pwrt_timer.sv
module rrs_pwrt_timer #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic por_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      cnt <= '0;
    end else if (!run_i) begin
      cnt <= '0;
    end else if (tick_i) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done_o = run_i && tick_i && (cnt == LAST);

  // R3
  pwrt_tick_only_chk: assert property (@(posedge clk) disable iff (por_i)
    (run_i && !tick_i) |=> (cnt == $past(cnt)) || !$past(run_i));

endmodule

// File: rtl/rrs_ost_counter.sv
module rrs_ost_counter #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic por_i,
  input  logic run_i,
  output logic done_o
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      cnt <= '0;
    end else if (!run_i) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done_o = run_i && (cnt == LAST);

endmodule

// File: rtl/reset_release_seq.sv
module reset_release_seq
  import rrs_pkg::*;
#(
  parameter int BOR_LEVELS   = 4,
  parameter int FILTER_TICKS = 3,
  parameter int PWRT_TICKS   = 8,
  parameter int OST_CYCLES   = 1024,
  localparam int SEL_W       = $clog2(BOR_LEVELS)
) (
  input  logic                  clk,
  input  logic                  por_i,
  input  logic [BOR_LEVELS-1:0] bor_flag_i,
  input  logic [SEL_W-1:0]      bor_sel_i,
  input  logic                  bor_en_i,
  input  logic                  pwrt_en_i,
  input  logic [2:0]            osc_mode_i,
  input  logic                  wake_i,
  input  logic                  slow_tick_i,
  output logic                  core_rst_o,
  output logic                  cause_por_o,
  output logic                  cause_bor_o,
  output logic                  cause_wake_o
);

  phase_e state, state_n;
  cause_e cause, cause_n;

  logic bor_low, bor_trip;
  logic pwrt_done, ost_done;
  logic crystal;

  assign crystal = is_crystal(osc_mode_i);

  rrs_bor_filter #(
    .LEVELS       (BOR_LEVELS),
    .FILTER_TICKS (FILTER_TICKS)
  ) u_filter (
    .clk     (clk),
    .por_i   (por_i),
    .flags_i (bor_flag_i),
    .sel_i   (bor_sel_i),
    .en_i    (bor_en_i),
    .tick_i  (slow_tick_i),
    .low_o   (bor_low),
    .trip_o  (bor_trip)
  );

  rrs_pwrt_timer #(
    .TICKS (PWRT_TICKS)
  ) u_pwrt (
    .clk    (clk),
    .por_i  (por_i),
    .run_i  (state == PH_PWRT),
    .tick_i (slow_tick_i),
    .done_o (pwrt_done)
  );

  rrs_ost_counter #(
    .CYCLES (OST_CYCLES)
  ) u_ost (
    .clk    (clk),
    .por_i  (por_i),
    .run_i  (state == PH_OST),
    .done_o (ost_done)
  );

  always_comb begin
    state_n = state;
    cause_n = cause;
    unique case (state)
      PH_POR: begin
        if (pwrt_en_i)    state_n = PH_PWRT;
        else if (crystal) state_n = PH_OST;
        else              state_n = PH_RUN;
      end
      PH_BROWNOUT: begin
        if (!bor_low) state_n = PH_PWRT;
      end
      PH_PWRT: begin
        if (bor_low) begin
          state_n = PH_BROWNOUT;
          cause_n = CAUSE_BOR;
        end else if (pwrt_done) begin
          state_n = crystal ? PH_OST : PH_RUN;
        end
      end
      PH_OST: begin
        if (bor_trip) begin
          state_n = PH_BROWNOUT;
          cause_n = CAUSE_BOR;
        end else if (ost_done) begin
          state_n = PH_RUN;
        end
      end
      PH_RUN: begin
        if (bor_trip) begin
          state_n = PH_BROWNOUT;
          cause_n = CAUSE_BOR;
        end else if (wake_i) begin
          cause_n = CAUSE_WAKE;
          if (crystal) state_n = PH_OST;
        end
      end
      default: state_n = PH_POR;
    endcase
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      state <= PH_POR;
      cause <= CAUSE_POR;
    end else begin
      state <= state_n;
      cause <= cause_n;
    end
  end

  assign core_rst_o   = (state != PH_RUN);
  assign cause_por_o  = (cause == CAUSE_POR);
  assign cause_bor_o  = (cause == CAUSE_BOR);
  assign cause_wake_o = (cause == CAUSE_WAKE);

  // R9
  bor_entry_chk: assert property (@(posedge clk) disable iff (por_i)
    (state == PH_RUN && bor_trip) |=> (core_rst_o && cause_bor_o));

  // R9
  bor_hold_chk: assert property (@(posedge clk) disable iff (por_i)
    (state == PH_BROWNOUT && bor_low) |=> core_rst_o);

  // R10
  bor_to_pwrt_chk: assert property (@(posedge clk) disable iff (por_i)
    (state == PH_BROWNOUT && !bor_low) |=> (state == PH_PWRT));

  // R11
  pwrt_redip_chk: assert property (@(posedge clk) disable iff (por_i)
    (state == PH_PWRT && bor_low) |=> (state == PH_BROWNOUT));

  // R5
  ost_hold_chk: assert property (@(posedge clk) disable iff (por_i)
    (state == PH_OST && !ost_done && !bor_trip) |=> core_rst_o);

  // R12
  wake_ost_chk: assert property (@(posedge clk) disable iff (por_i)
    (state == PH_RUN && wake_i && !bor_trip && crystal) |=> (state == PH_OST && cause_wake_o));

  // R13
  cause_onehot_chk: assert property (@(posedge clk) disable iff (por_i)
    $countones({cause_por_o, cause_bor_o, cause_wake_o}) == 1);

endmodule

// File: tb/reset_release_seq_tb.sv
module reset_release_seq_tb_top;

  localparam int FT = 3;
  localparam int PT = 8;
  localparam int OC = 1024;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic [3:0] flags = 4'b0000;
  logic [1:0] sel = 2'd2;
  logic       bor_en = 1'b1;
  logic       pwrt_en = 1'b1;
  logic [2:0] osc = 3'd3;
  logic       wake = 1'b0;
  logic       tick = 1'b0;
  logic       core_rst, c_por, c_bor, c_wake;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  reset_release_seq #(
    .FILTER_TICKS (FT),
    .PWRT_TICKS   (PT),
    .OST_CYCLES   (OC)
  ) dut_i (
    .clk          (clk),
    .por_i        (por),
    .bor_flag_i   (flags),
    .bor_sel_i    (sel),
    .bor_en_i     (bor_en),
    .pwrt_en_i    (pwrt_en),
    .osc_mode_i   (osc),
    .wake_i       (wake),
    .slow_tick_i  (tick),
    .core_rst_o   (core_rst),
    .cause_por_o  (c_por),
    .cause_bor_o  (c_bor),
    .cause_wake_o (c_wake)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // slow tick: one pulse every four clk cycles
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      tick = (n % 4 == 0);
    end
  end

  // behavioural reference: 0 power-on, 1 brown-out, 2 timer, 3 start-up, 4 run
  int m_ph = 0, m_f = 0, m_p = 0, m_o = 0, m_cause = 0;

  initial begin
    forever begin
      @(posedge clk);
      if (por) begin
        m_ph = 0; m_f = 0; m_p = 0; m_o = 0; m_cause = 0;
      end else begin
        bit lo, tr, xt;
        int nph, nc;
        lo = bor_en && flags[sel];
        tr = lo && (m_f == FT);
        xt = (osc < 3);
        nph = m_ph;
        nc = m_cause;
        case (m_ph)
          0: nph = pwrt_en ? 2 : (xt ? 3 : 4);
          1: if (!lo) nph = 2;
          2: if (lo) begin nph = 1; nc = 1; end
             else if (tick && m_p == PT - 1) nph = xt ? 3 : 4;
          3: if (tr) begin nph = 1; nc = 1; end
             else if (m_o == OC - 1) nph = 4;
          default: if (tr) begin nph = 1; nc = 1; end
                   else if (wake) begin nc = 2; if (xt) nph = 3; end
        endcase
        m_f = !lo ? 0 : ((tick && m_f < FT) ? m_f + 1 : m_f);
        m_p = (m_ph == 2) ? m_p + int'(tick) : 0;
        m_o = (m_ph == 3) ? m_o + 1 : 0;
        m_ph = nph;
        m_cause = nc;
      end
    end
  end

  // per-cycle comparison against the reference
  initial begin
    forever begin
      @(negedge clk);
      if (!finished) begin
        check(core_rst == (m_ph != 4), "R2 core_rst vs model", int'(core_rst), int'(m_ph != 4));
        check({c_por, c_bor, c_wake} == (3'b100 >> m_cause), "R13 cause vs model",
              int'({c_por, c_bor, c_wake}), int'(3'b100 >> m_cause));
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_then_release(input string tag, input int hold, input int limit);
    int waited = 0;
    cycles(hold);
    check(core_rst == 1'b1, tag, int'(core_rst), 1);
    waited = hold;
    while (core_rst && waited < limit) begin
      cycles(1);
      waited++;
    end
    check(core_rst == 1'b0, tag, int'(core_rst), 0);
  endtask

  task automatic do_por();
    @(negedge clk); #2 por = 1'b1;
    cycles(3);
    check(core_rst && c_por && !c_bor && !c_wake, "R1 reset state during power-on",
          int'({core_rst, c_por, c_bor, c_wake}), 4'b1100);
    @(negedge clk); #2 por = 1'b0;
  endtask

  initial begin
    #3;
    cycles(3);
    check(core_rst && c_por && !c_bor && !c_wake, "R1 reset state at start",
          int'({core_rst, c_por, c_bor, c_wake}), 4'b1100);
    @(negedge clk); #2 por = 1'b0;
    // R3: timer enabled, non-crystal: held for PT slow ticks
    hold_then_release("R3 power-up timer length", 20, 40);

    // R4: timer disabled, non-crystal: immediate release
    pwrt_en = 1'b0;
    do_por();
    cycles(3);
    check(core_rst == 1'b0, "R4 timer skipped on power-on", int'(core_rst), 0);

    // R5: timer disabled, crystal code 1: start-up count only
    osc = 3'd1;
    do_por();
    hold_then_release("R5 start-up count for crystal", 1000, 1040);
    osc = 3'd5;

    // R6: short dip on selected flag is ignored
    flags[2] = 1'b1; cycles(5); flags[2] = 1'b0;
    cycles(10);
    check(core_rst == 1'b0 && c_por, "R6 short dip filtered", int'(core_rst), 0);

    // R7: unselected flag has no effect
    flags[1] = 1'b1; cycles(40); flags[1] = 1'b0;
    check(core_rst == 1'b0 && c_por, "R7 unselected flag ignored", int'(core_rst), 0);

    // R8: detection disabled
    bor_en = 1'b0;
    flags[2] = 1'b1; cycles(40); flags[2] = 1'b0;
    check(core_rst == 1'b0 && c_por, "R8 disabled detection ignored", int'(core_rst), 0);
    bor_en = 1'b1;
    cycles(2);

    // R9: qualified brown-out, held while low
    flags[2] = 1'b1; cycles(40);
    check(core_rst && c_bor, "R9 brown-out held", int'({core_rst, c_bor}), 3);
    // R10: timer runs though pwrt_en is 0
    flags[2] = 1'b0;
    hold_then_release("R10 timer after brown-out", 20, 40);

    // R11: dip during timer restarts it
    flags[2] = 1'b1; cycles(40); flags[2] = 1'b0;
    cycles(20);
    flags[2] = 1'b1; cycles(2); flags[2] = 1'b0;
    hold_then_release("R11 timer restarted after re-dip", 20, 40);

    // R12: wake with non-crystal keeps running
    cycles(2);
    wake = 1'b1; cycles(1); wake = 1'b0;
    cycles(2);
    check(core_rst == 1'b0 && c_wake, "R12 wake non-crystal", int'({core_rst, c_wake}), 1);
    // R12: wake with crystal code 2 holds for start-up count
    osc = 3'd2;
    wake = 1'b1; cycles(1); wake = 1'b0;
    check(c_wake == 1'b1, "R12 wake cause", int'(c_wake), 1);
    hold_then_release("R12 wake crystal start-up", 1000, 1040);

    // R13: a new power-on clears the wake cause
    osc = 3'd4;
    do_por();
    cycles(3);
    check(c_por && !c_wake && !c_bor, "R13 cause cleared by power-on",
          int'({c_por, c_bor, c_wake}), 4);

    cycles(50);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    finished = 1;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule